// File: doc/BRIEF.md
# Paged DMA Translation Engine

This block is a single-channel DMA engine. It moves a byte stream between a device and physical memory. Software gives it a logical start address and a byte count. Every logical address is remapped through a page table that lives in memory. Each 4 KB logical page owns one 32-bit table slot, and slots sit eight bytes apart from a programmable table base. The physical frame stored in a slot replaces the page number of the logical address, and the offset within the page passes through unchanged.

One enable register controls the transfer. Its run bit starts or pauses the engine, and its direction bit picks between a device-to-memory transfer and a memory-to-device transfer. The engine reads a table slot once at the start and again each time the logical pointer crosses into a new page. It then issues one memory request per byte. A transfer ends after the programmed number of bytes, or earlier when an inbound device stream flags its final byte. At the end the count register reads zero and a done flag is raised. A static input selects the byte order in which table slots are decoded.

Top module: `pgdma_top`

## Requirements
- R1: After reset, every register reads zero, and `mem_req_o`, `done_o` and `dev_in_ready_o` are low.
- R2: The register map uses byte offsets on `reg_addr_i`:
  - 0x00 mode (plain storage).
  - 0x08 enable: bit0 run, bit1 direction, bit8 done (read-only).
  - 0x10 count, 0x18 logical start address, 0x20 table base, 0x28 table limit (plain storage).
  - 0x30 invalidate: writes have no effect on any register, and it reads zero.
  - Any other offset reads zero.
- R3: A table read is a word request (`mem_word_o`=1) at table_base + (logical_address >> 12) * 8. The request holds its address until `mem_ack_i`.
- R4: `mem_rdata_i[7:0]` carries the byte at the request address, and higher lanes carry the following bytes. With `big_endian_i`=0 the slot value is `mem_rdata_i` as is. With `big_endian_i`=1 the four bytes are reversed.
- R5: Each byte request goes to the slot value with its low 12 bits cleared, plus the low 12 bits of the current logical address.
- R6: A table read happens once at the start of a transfer and then only when the logical address crosses a 4 KB boundary.
- R7: With the direction bit clear, each byte taken from the device input is written to memory in order (`mem_we_o`=1, data on `mem_wdata_o`). `dev_out_valid_o` stays low.
- R8: With the direction bit set, each byte is read from memory (`mem_rdata_i[7:0]`) and presented on the device output in order. `dev_in_ready_o` stays low, so inbound data is refused.
- R9: A transfer ends after count bytes, or, when inbound, after the byte accepted with `dev_in_last_i`=1. Afterwards the count register reads zero.
- R10: The done flag (`done_o`, enable bit8) rises at the end of a transfer. Any write to the enable register clears it.
- R11: A transfer starts only on an enable write with run=1 while idle and a nonzero count. Clearing run during a transfer holds back further memory requests until run is set again. An enable write during a transfer does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian_i | input | 1 | Byte order of table slots (static) |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from offset) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a byte write |
| mem_word_o | output | 1 | Request is a 32-bit table read |
| mem_addr_o | output | 32 | Physical request address |
| mem_wdata_o | output | 8 | Byte write data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| dev_in_valid_i | input | 1 | Inbound device byte valid |
| dev_in_data_i | input | 8 | Inbound device byte |
| dev_in_last_i | input | 1 | Inbound byte is the final one of the stream |
| dev_in_ready_o | output | 1 | Engine accepts an inbound byte |
| dev_out_valid_o | output | 1 | Outbound byte valid |
| dev_out_data_o | output | 8 | Outbound byte |
| dev_out_ready_i | input | 1 | Device accepts the outbound byte |
| done_o | output | 1 | Transfer-finished flag |

## Verification
Directed transfers each target one address situation:
- A run inside a single page.
- A run that crosses one page boundary two bytes after its start.
- A run that ends at the last byte of a page.
- An inbound stream that stops early with its last flag.

Random transfers then vary direction, slot byte order, start offset, length and early stream end. Memory acknowledge and device handshakes get random gaps. The number of table reads tells a per-page lookup apart from a per-byte one. Byte-order changes show whether slots are decoded with the selected order. Comparing every physical byte address with a bench-side page map separates frame replacement from offset handling. A pause test and a zero-count start show that run gating and start qualification stop memory traffic at the ports.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_MODE  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_ENA   = 6'h08;
  localparam logic [OFS_W-1:0] OFS_CNT   = 6'h10;
  localparam logic [OFS_W-1:0] OFS_LADDR = 6'h18;
  localparam logic [OFS_W-1:0] OFS_TBASE = 6'h20;
  localparam logic [OFS_W-1:0] OFS_TLIM  = 6'h28;
  localparam logic [OFS_W-1:0] OFS_INVAL = 6'h30;

  localparam int unsigned ENA_RUN_BIT  = 0;
  localparam int unsigned ENA_DIR_BIT  = 1;
  localparam int unsigned ENA_DONE_BIT = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_FETCH,
    ST_DEV_IN,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_DEV_OUT
  } dma_state_e;

  function automatic logic [31:0] swap_bytes32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/pgdma_regs.sv
module pgdma_regs
  import pgdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [OFS_W-1:0]   addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               busy_i,
  input  logic               xfer_end_i,
  output logic               run_o,
  output logic               start_o,
  output logic               start_dir_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [ADDR_W-1:0]  laddr_o,
  output logic [ADDR_W-1:0]  tbase_o,
  output logic               done_o
);
  logic [REG_W-1:0]  mode_q;
  logic [REG_W-1:0]  tlim_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] laddr_q;
  logic [ADDR_W-1:0] tbase_q;
  logic              run_q;
  logic              dir_q;
  logic              done_q;
  logic              ena_wr;

  assign ena_wr      = wr_en_i && (addr_i == OFS_ENA);
  assign start_o     = ena_wr && wdata_i[ENA_RUN_BIT] && (cnt_q != '0) && !busy_i;
  assign start_dir_o = wdata_i[ENA_DIR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tlim_q  <= '0;
      cnt_q   <= '0;
      laddr_q <= '0;
      tbase_q <= '0;
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          OFS_MODE:  mode_q  <= wdata_i;
          OFS_ENA: begin
            run_q  <= wdata_i[ENA_RUN_BIT];
            dir_q  <= wdata_i[ENA_DIR_BIT];
            done_q <= 1'b0;
          end
          OFS_CNT:   cnt_q   <= CNT_W'(wdata_i);
          OFS_LADDR: laddr_q <= ADDR_W'(wdata_i);
          OFS_TBASE: tbase_q <= ADDR_W'(wdata_i);
          OFS_TLIM:  tlim_q  <= wdata_i;
          default: ;
        endcase
      end
      if (xfer_end_i) begin
        done_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE:  rdata_o = mode_q;
      OFS_ENA: begin
        rdata_o[ENA_RUN_BIT]  = run_q;
        rdata_o[ENA_DIR_BIT]  = dir_q;
        rdata_o[ENA_DONE_BIT] = done_q;
      end
      OFS_CNT:   rdata_o = REG_W'(cnt_q);
      OFS_LADDR: rdata_o = REG_W'(laddr_q);
      OFS_TBASE: rdata_o = REG_W'(tbase_q);
      OFS_TLIM:  rdata_o = tlim_q;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o   = run_q;
  assign cnt_o   = cnt_q;
  assign laddr_o = laddr_q;
  assign tbase_o = tbase_q;
  assign done_o  = done_q;

  // R9: the end of a transfer empties the count and raises done
  assert_end_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end_i |=> (cnt_q == '0) && done_q);

  // R10: an enable write without a coinciding end leaves done low
  assert_done_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && !xfer_end_i) |=> !done_q);
endmodule

// File: rtl/pgdma_xlate.sv
module pgdma_xlate
  import pgdma_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned STRIDE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_i,
  input  logic [ADDR_W-1:0] tbase_i,
  input  logic [ADDR_W-1:0] laddr_i,
  input  logic [31:0]       raw_i,
  input  logic              load_i,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic [ADDR_W-1:0] phys_addr_o
);
  localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS;

  logic [FRAME_W-1:0] frame_q;
  logic [ADDR_W-1:0]  slot_value;

  function automatic logic [ADDR_W-1:0] slot_address(input logic [ADDR_W-1:0] base,
                                                     input logic [ADDR_W-1:0] la);
    return base + ((la >> PAGE_BITS) << STRIDE_LOG2);
  endfunction

  function automatic logic [ADDR_W-1:0] decode_slot(input logic [31:0] raw, input logic be);
    return ADDR_W'(be ? swap_bytes32(raw) : raw);
  endfunction

  assign slot_value  = decode_slot(raw_i, big_endian_i);
  assign tbl_addr_o  = slot_address(tbase_i, laddr_i);
  assign phys_addr_o = {frame_q, laddr_i[PAGE_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)      frame_q <= '0;
    else if (load_i) frame_q <= slot_value[ADDR_W-1:PAGE_BITS];
  end
endmodule

// File: rtl/pgdma_ctrl.sv
module pgdma_ctrl
  import pgdma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_dir_i,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] laddr0_i,
  input  logic [CNT_W-1:0]  cnt0_i,
  output logic              busy_o,
  output logic              xfer_end_o,
  output logic [ADDR_W-1:0] lptr_o,
  output logic              frame_load_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_word_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rbyte_i,
  output logic [7:0]        mem_wdata_o,
  input  logic              dev_in_valid_i,
  input  logic [7:0]        dev_in_data_i,
  input  logic              dev_in_last_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [7:0]        dev_out_data_o,
  input  logic              dev_out_ready_i
);
  dma_state_e        state;
  logic [ADDR_W-1:0] lptr;
  logic [CNT_W-1:0]  rem;
  logic              dir_q;
  logic              need_fetch;
  logic              first_q;
  logic              last_q;
  logic [7:0]        byte_q;

  // named events for the assertions and the datapath
  logic              byte_done;
  logic              final_byte;
  logic [ADDR_W-1:0] next_lptr;
  logic              cross_page;

  assign byte_done  = ((state == ST_MEM_WR) && mem_ack_i) ||
                      ((state == ST_DEV_OUT) && dev_out_ready_i);
  assign final_byte = (rem == CNT_W'(1)) || last_q;
  assign next_lptr  = lptr + ADDR_W'(1);
  assign cross_page = (next_lptr[PAGE_BITS-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lptr       <= '0;
      rem        <= '0;
      dir_q      <= 1'b0;
      need_fetch <= 1'b0;
      first_q    <= 1'b0;
      last_q     <= 1'b0;
      byte_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          lptr       <= laddr0_i;
          rem        <= cnt0_i;
          dir_q      <= start_dir_i;
          need_fetch <= 1'b1;
          first_q    <= 1'b1;
          last_q     <= 1'b0;
          state      <= ST_STEP;
        end
        ST_STEP: if (run_i) begin
          if (need_fetch) state <= ST_FETCH;
          else            state <= dir_q ? ST_MEM_RD : ST_DEV_IN;
        end
        ST_FETCH: if (mem_ack_i) begin
          need_fetch <= 1'b0;
          first_q    <= 1'b0;
          state      <= dir_q ? ST_MEM_RD : ST_DEV_IN;
        end
        ST_DEV_IN: if (dev_in_valid_i) begin
          byte_q <= dev_in_data_i;
          last_q <= dev_in_last_i;
          state  <= ST_MEM_WR;
        end
        ST_MEM_RD: if (mem_ack_i) begin
          byte_q <= mem_rbyte_i;
          state  <= ST_DEV_OUT;
        end
        default: ;
      endcase
      if (byte_done) begin
        if (final_byte) begin
          state <= ST_IDLE;
        end else begin
          lptr       <= next_lptr;
          rem        <= rem - CNT_W'(1);
          need_fetch <= cross_page;
          state      <= ST_STEP;
        end
      end
    end
  end

  assign busy_o          = (state != ST_IDLE);
  assign xfer_end_o      = byte_done && final_byte;
  assign lptr_o          = lptr;
  assign frame_load_o    = (state == ST_FETCH) && mem_ack_i;
  assign mem_req_o       = (state == ST_FETCH) || (state == ST_MEM_WR) || (state == ST_MEM_RD);
  assign mem_we_o        = (state == ST_MEM_WR);
  assign mem_word_o      = (state == ST_FETCH);
  assign mem_wdata_o     = byte_q;
  assign dev_in_ready_o  = (state == ST_DEV_IN);
  assign dev_out_valid_o = (state == ST_DEV_OUT);
  assign dev_out_data_o  = byte_q;

  // R3: a request keeps its kind and page pointer until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_we_o) && $stable(mem_word_o) && $stable(lptr));

  // R6: after the first lookup, a slot is read only at a page start
  assert_refetch_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load_o && !first_q) |-> (lptr[PAGE_BITS-1:0] == '0));

  // R7: no outbound byte offered during an inbound transfer
  assert_out_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid_o |-> dir_q);

  // R8: inbound data is refused while the transfer is outbound
  assert_in_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_ready_o |-> !dir_q);

  // R11: with run low between bytes, no new memory request appears
  assert_paused_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STEP) && !run_i) |=> !mem_req_o);
endmodule

// File: rtl/pgdma_top.sv
module pgdma_top
  import pgdma_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned STRIDE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_i,
  input  logic              reg_wr_en_i,
  input  logic [5:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_word_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              dev_in_valid_i,
  input  logic [7:0]        dev_in_data_i,
  input  logic              dev_in_last_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [7:0]        dev_out_data_o,
  input  logic              dev_out_ready_i,
  output logic              done_o
);
  logic              busy, xfer_end, run, start, start_dir, frame_load;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] laddr0, tbase, lptr, tbl_addr, phys_addr;

  pgdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(reg_wr_en_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .xfer_end_i(xfer_end),
    .run_o(run), .start_o(start), .start_dir_o(start_dir),
    .cnt_o(cnt), .laddr_o(laddr0), .tbase_o(tbase), .done_o(done_o)
  );

  pgdma_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .STRIDE_LOG2(STRIDE_LOG2)) xlate_i (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
    .tbase_i(tbase), .laddr_i(lptr), .raw_i(mem_rdata_i), .load_i(frame_load),
    .tbl_addr_o(tbl_addr), .phys_addr_o(phys_addr)
  );

  pgdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .start_dir_i(start_dir), .run_i(run),
    .laddr0_i(laddr0), .cnt0_i(cnt),
    .busy_o(busy), .xfer_end_o(xfer_end), .lptr_o(lptr), .frame_load_o(frame_load),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_word_o(mem_word_o),
    .mem_ack_i(mem_ack_i), .mem_rbyte_i(mem_rdata_i[7:0]), .mem_wdata_o(mem_wdata_o),
    .dev_in_valid_i(dev_in_valid_i), .dev_in_data_i(dev_in_data_i), .dev_in_last_i(dev_in_last_i),
    .dev_in_ready_o(dev_in_ready_o),
    .dev_out_valid_o(dev_out_valid_o), .dev_out_data_o(dev_out_data_o),
    .dev_out_ready_i(dev_out_ready_i)
  );

  assign mem_addr_o = mem_word_o ? tbl_addr : phys_addr;
endmodule

// File: tb/pgdma_top_tb_top.sv
module pgdma_top_tb_top;
  localparam logic [31:0] TBASE = 32'h0000_C000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_word, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [7:0]  mem_wdata;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        done;

  pgdma_top dut_i (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian),
    .reg_wr_en_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_word_o(mem_word), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dev_in_valid_i(in_valid), .dev_in_data_i(in_data), .dev_in_last_i(in_last),
    .dev_in_ready_o(in_ready), .dev_out_valid_o(out_valid), .dev_out_data_o(out_data),
    .dev_out_ready_i(out_ready), .done_o(done)
  );

  always #10 clk = ~clk;

  logic [7:0] bmem [0:65535];
  logic [7:0] in_buf [0:1023];
  logic [7:0] rx_buf [0:1023];
  int n_chk = 0, n_fail = 0;
  int in_len = 0, in_idx = 0, rx_n = 0;
  bit in_on = 0, in_last_en = 0, in_pend = 0, hold_ready = 0;
  bit xfer_act = 0, out_dir = 0;
  int data_k = 0, fetch_n = 0, fetch_bad = 0, addr_bad = 0, dir_viol = 0, req_seen = 0;
  logic [31:0] cur_la = '0;

  function automatic logic [31:0] frame_of(input logic [31:0] pg);
    return ((((pg * 3) + 1) % 8) + 1) << 12;
  endfunction
  function automatic logic [31:0] exp_phys(input logic [31:0] la);
    return frame_of(la >> 12) + (la & 32'hFFF);
  endfunction
  function automatic logic [31:0] exp_slot(input logic [31:0] la);
    return TBASE + (la >> 12) * 8;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  // memory responder with random acknowledge gaps
  initial forever begin
    @(negedge clk);
    mem_ack = 1'b0;
    if (mem_req) begin
      req_seen++;
      if ($urandom % 3 != 0) begin
        mem_ack = 1'b1;
        if (mem_word) begin
          fetch_n++;
          if (mem_addr != exp_slot(cur_la + data_k)) fetch_bad++;
          mem_rdata = {bmem[mem_addr[15:0] + 16'd3], bmem[mem_addr[15:0] + 16'd2],
                       bmem[mem_addr[15:0] + 16'd1], bmem[mem_addr[15:0]]};
        end else begin
          if (mem_addr != exp_phys(cur_la + data_k)) addr_bad++;
          data_k++;
          if (mem_we) bmem[mem_addr[15:0]] = mem_wdata;
          else        mem_rdata = {24'h0, bmem[mem_addr[15:0]]};
        end
      end
    end
  end

  // inbound device source and direction monitor
  initial forever begin
    @(negedge clk);
    if (in_pend) in_idx++;
    in_pend = 0;
    if (in_on && in_idx < in_len) begin
      in_valid = ($urandom % 4 != 0);
      in_data  = in_buf[in_idx];
      in_last  = in_last_en && (in_idx == in_len - 1);
    end else begin
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    in_pend = in_valid && in_ready;
    if (xfer_act && ((out_dir && in_ready) || (!out_dir && out_valid))) dir_viol++;
  end

  // outbound device sink
  initial forever begin
    @(negedge clk);
    out_ready = hold_ready ? 1'b0 : ($urandom % 3 != 0);
    if (out_valid && out_ready) begin
      rx_buf[rx_n] = out_data;
      rx_n++;
    end
  end

  task automatic setup_table(input bit be);
    for (int pg = 0; pg < 64; pg++) begin
      logic [31:0] e;
      logic [15:0] a;
      e = frame_of(pg) | 32'h5A5;
      a = 16'(TBASE + pg * 8);
      for (int k = 0; k < 4; k++)
        bmem[a + 16'(k)] = be ? e[8*(3-k) +: 8] : e[8*k +: 8];
      for (int k = 4; k < 8; k++) bmem[a + 16'(k)] = 8'hEE;
    end
  endtask

  task automatic wait_done(output bit ok);
    int t;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    ok = done;
  endtask

  task automatic run_xfer(input bit dir, input bit be, input logic [31:0] la, input int cnt,
                          input int stream_n, input bit use_last);
    int n_eff, bad, pages;
    bit ok;
    logic [31:0] r;
    big_endian = be;
    setup_table(be);
    cur_la = la; data_k = 0; fetch_n = 0; fetch_bad = 0; addr_bad = 0; rx_n = 0; dir_viol = 0;
    n_eff = (!dir && use_last && stream_n < cnt) ? stream_n : cnt;
    if (!dir) begin
      for (int i = 0; i < 1024; i++) in_buf[i] = 8'($urandom);
      in_len = use_last ? stream_n : cnt;
      in_last_en = use_last; in_idx = 0; in_pend = 0; in_on = 1;
    end
    out_dir = dir; xfer_act = 1;
    reg_write(6'h20, TBASE);
    reg_write(6'h18, la);
    reg_write(6'h10, 32'(cnt));
    reg_write(6'h08, {30'h0, dir, 1'b1});
    wait_done(ok);
    repeat (3) @(negedge clk);
    xfer_act = 0; in_on = 0;
    chk(ok, "R9 transfer finished", 32'(ok), 32'd1);
    chk(data_k == n_eff, dir ? "R8 byte requests" : "R7 byte requests", 32'(data_k), 32'(n_eff));
    bad = 0;
    if (!dir) begin
      for (int i = 0; i < n_eff; i++)
        if (bmem[exp_phys(la + i)] !== in_buf[i]) bad++;
      chk(bad == 0, "R7 bytes written", 32'(bad), 32'd0);
    end else begin
      for (int i = 0; i < n_eff; i++)
        if (rx_buf[i] !== bmem[exp_phys(la + i)]) bad++;
      chk(bad == 0 && rx_n == n_eff, "R8 bytes delivered", 32'(bad), 32'd0);
    end
    chk(addr_bad == 0, "R5 physical byte address", 32'(addr_bad), 32'd0);
    chk(fetch_bad == 0, "R3 R4 slot address", 32'(fetch_bad), 32'd0);
    pages = ((la + n_eff - 1) >> 12) - (la >> 12) + 1;
    chk(fetch_n == pages, "R6 one lookup per page", 32'(fetch_n), 32'(pages));
    chk(dir_viol == 0, dir ? "R8 inbound refused" : "R7 no outbound", 32'(dir_viol), 32'd0);
    reg_read(6'h10, r);
    chk(r == 32'd0, "R9 count reads zero", r, 32'd0);
    reg_read(6'h08, r);
    chk(r[8] == 1'b1, "R10 done raised", 32'(r[8]), 32'd1);
    reg_write(6'h08, 32'h0);
    reg_read(6'h08, r);
    chk(r[8] == 1'b0 && !done, "R10 done cleared by enable write", 32'(r[8]), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (R9) actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r, v;
    bit ok;
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 65536; i++) bmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!mem_req && !done && !in_ready, "R1 outputs idle in reset", {mem_req, done, in_ready}, 0);
    rst_n = 1'b1;

    // R1: reset contents
    for (int a = 0; a < 64; a += 8) begin
      reg_read(6'(a), r);
      chk(r == 0, "R1 register reset value", r, 32'd0);
    end

    // R2: readback and invalidate
    v = $urandom; reg_write(6'h00, v); reg_read(6'h00, r); chk(r == v, "R2 mode", r, v);
    v = $urandom; reg_write(6'h28, v); reg_read(6'h28, r); chk(r == v, "R2 table limit", r, v);
    v = $urandom; reg_write(6'h20, v); reg_read(6'h20, r); chk(r == v, "R2 table base", r, v);
    reg_write(6'h18, 32'h1234_5678); reg_read(6'h18, r); chk(r == 32'h1234_5678, "R2 address", r, 32'h1234_5678);
    reg_write(6'h30, 32'hFFFF_FFFF);
    reg_read(6'h20, r); chk(r == v, "R2 invalidate no effect", r, v);
    reg_read(6'h30, r); chk(r == 0, "R2 invalidate reads zero", r, 32'd0);
    reg_read(6'h38, r); chk(r == 0, "R2 unmapped reads zero", r, 32'd0);

    // R11: zero count does not start
    reg_write(6'h10, 32'h0);
    req_seen = 0;
    reg_write(6'h08, 32'h1);
    repeat (20) @(negedge clk);
    chk(req_seen == 0 && !done, "R11 zero count no start", 32'(req_seen), 32'd0);
    reg_write(6'h08, 32'h0);

    // directed transfers
    run_xfer(1'b0, 1'b0, 32'h0000_2100, 64, 64, 1'b0);
    run_xfer(1'b1, 1'b1, 32'h0000_5F80, 300, 300, 1'b0);
    run_xfer(1'b0, 1'b1, 32'h0000_7FFE, 50, 20, 1'b1);
    run_xfer(1'b1, 1'b0, 32'h0000_3FFF, 1, 1, 1'b0);

    // random transfers
    for (int t = 0; t < 8; t++) begin
      bit d, b, ul;
      int c, s;
      logic [31:0] la;
      d  = 1'($urandom);
      b  = 1'($urandom);
      la = (($urandom % 60) << 12) | ($urandom % 4096);
      c  = 1 + $urandom % 400;
      ul = !d && ($urandom % 3 == 0);
      s  = 1 + $urandom % c;
      run_xfer(d, b, la, c, s, ul);
    end

    // R11: pause and resume, no restart on enable write while busy
    big_endian = 1'b0; setup_table(1'b0);
    cur_la = 32'h0000_1010; data_k = 0; fetch_n = 0; fetch_bad = 0; addr_bad = 0; rx_n = 0;
    hold_ready = 1;
    reg_write(6'h18, 32'h0000_1010);
    reg_write(6'h10, 32'd10);
    reg_write(6'h08, 32'h3);
    repeat (30) @(negedge clk);
    reg_write(6'h08, 32'h2);
    hold_ready = 0;
    repeat (40) @(negedge clk);
    chk(data_k == 1 && rx_n == 1 && !done, "R11 paused after one byte", 32'(data_k), 32'd1);
    reg_write(6'h08, 32'h3);
    wait_done(ok);
    repeat (3) @(negedge clk);
    chk(ok && rx_n == 10 && data_k == 10, "R11 resumed to completion", 32'(rx_n), 32'd10);
    chk(addr_bad == 0 && fetch_n == 1, "R11 R6 resumed without restart", 32'(fetch_n), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule